// File: doc/BRIEF.md
# Accumulator ALU with Flags

This block is the arithmetic-logic unit of a small 8-bit accumulator machine. It holds the accumulator and a five-bit flags register. Each cycle in which `valid_i` is high, it applies the operation on `op_i` to the accumulator and to a second operand `opnd_i`. That operand may come from a register, from memory or from an immediate field, as the surrounding core chooses. Two-operand results go back into the accumulator, and the carry flag feeds the add-with-carry and subtract-with-borrow operations.

Increment and decrement work on the operand, not on the accumulator. Their result is combinational on `idu_res_o`, qualified by `idu_we_o`, so the core can write it to any register or to memory. Their flags are registered like those of every other operation. Instruction decode, the register file, memory access and decimal adjust belong to the core around the block.

Top module: `acc_alu`

## Requirements
- R1: With `valid_i` high, op codes 0 ADD, 1 ADC, 2 SUB, 3 SBB, 4 AND, 5 XOR, 6 OR and 7 LOAD set the accumulator on the next clock edge to A+B, A+B+CY, A-B, A-B-CY, A&B, A^B, A|B and B (all mod 256), where A is the accumulator and B is `opnd_i`.
- R2: `flags_o` is {S,Z,AC,P,CY}: S is bit 4 and CY is bit 0. After ADD, ADC, SUB, SBB, AND, XOR, OR, INC and DEC, S is bit 7 of the result. Z is 1 when the result is zero. P is 1 when the result has an even number of 1 bits.
- R3: For ADD and ADC, AC is set when the low nibbles plus the carry-in exceed 15. For SUB and SBB, AC is set when (A&15)+(~B&15)+k exceeds 15, where k is 1 for SUB and 1-CY for SBB. For INC, AC is 1 when the operand's low nibble is 15. For DEC, AC is 1 when that low nibble is non-zero.
- R4: CY is the carry out of bit 7 for ADD and ADC. For SUB and SBB it is a borrow: it is set when B (plus CY for SBB) exceeds A, taken as unsigned values.
- R5: AND, XOR and OR clear both CY and AC.
- R6: Op 8 CMA inverts the accumulator. CMA and LOAD leave all flags unchanged.
- R7: Op 9 CMC inverts CY, and changes neither the other flags nor the accumulator.
- R8: Op 10 INC and op 11 DEC drive `opnd_i`+1 and `opnd_i`-1 (mod 256) on `idu_res_o` in the same cycle, with `idu_we_o` high. They update S, Z, AC and P and leave CY and the accumulator unchanged.
- R9: When `valid_i` is low, or when the op code is 12 to 15, the accumulator and the flags keep their values and `idu_we_o` is low.
- R10: While `rst_ni` is low, the accumulator and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Operation code |
| opnd_i | input | 8 | Second operand (register, memory or immediate) |
| acc_o | output | 8 | Accumulator |
| flags_o | output | 5 | {S,Z,AC,P,CY} |
| idu_res_o | output | 8 | Increment/decrement result |
| idu_we_o | output | 1 | Increment/decrement result valid |

## Verification
The assertions assume that `op_i` and `opnd_i` are stable around each rising edge while `valid_i` is high. They also assume that `valid_i` is never unknown once reset is released. The bench drives every input on the falling edge and releases `valid_i` just after the edge that consumes the operation, so each operation is applied exactly once. The values the flag assertions look at one cycle later come only from that single strobed operation.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_AND  = 4'd4,
    OP_XOR  = 4'd5,
    OP_OR   = 4'd6,
    OP_LOAD = 4'd7,
    OP_CMA  = 4'd8,
    OP_CMC  = 4'd9,
    OP_INC  = 4'd10,
    OP_DEC  = 4'd11
  } alu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } alu_flags_t;
endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  output logic [W-1:0] sum_o,
  output logic         half_o,
  output logic         co_o
);
  localparam int H = W / 2;
  localparam int U = W - H;

  logic [H:0] lo;
  logic [U:0] hi;

  // split at the nibble boundary to expose the half carry
  assign lo = {1'b0, a_i[H-1:0]} + {1'b0, b_i[H-1:0]} + {{H{1'b0}}, ci_i};
  assign hi = {1'b0, a_i[W-1:H]} + {1'b0, b_i[W-1:H]} + {{U{1'b0}}, lo[H]};

  assign sum_o  = {hi[U-1:0], lo[H-1:0]};
  assign half_o = lo[H];
  assign co_o   = hi[U];
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_OR:   res_o = a_i | b_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/acc_alu_flag_gen.sv
module acc_alu_flag_gen #(
  parameter int W = 8
) (
  input  logic [W-1:0] res_i,
  output logic         s_o,
  output logic         z_o,
  output logic         p_o
);
  assign s_o = res_i[W-1];
  assign z_o = (res_i == '0);
  assign p_o = ~^res_i;  // even parity
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] opnd_i,
  output logic [W-1:0] acc_o,
  output logic [4:0]   flags_o,
  output logic [W-1:0] idu_res_o,
  output logic         idu_we_o
);
  alu_op_e    op;
  logic [W-1:0] acc_q, acc_d;
  alu_flags_t fl_q, fl_d;

  logic [W-1:0] add_a, add_b, add_sum, lu_res, fg_in;
  logic         add_ci, add_half, add_co;
  logic         fg_s, fg_z, fg_p;
  logic         is_logic, is_sub, is_idu;

  assign op = alu_op_e'(op_i);

  assign is_logic = (op == OP_AND) || (op == OP_XOR) || (op == OP_OR);
  assign is_sub   = (op == OP_SUB) || (op == OP_SBB);
  assign is_idu   = (op == OP_INC) || (op == OP_DEC);

  // operand steering for the shared adder
  always_comb begin
    add_a  = acc_q;
    add_b  = opnd_i;
    add_ci = 1'b0;
    unique case (op)
      OP_ADC: add_ci = fl_q.cy;
      OP_SUB: begin add_b = ~opnd_i; add_ci = 1'b1;     end
      OP_SBB: begin add_b = ~opnd_i; add_ci = ~fl_q.cy; end
      OP_INC: begin add_a = opnd_i;  add_b = '0; add_ci = 1'b1; end
      OP_DEC: begin add_a = opnd_i;  add_b = '1; add_ci = 1'b0; end
      default: ;
    endcase
  end

  acc_alu_adder #(.W(W)) u_adder (
    .a_i(add_a), .b_i(add_b), .ci_i(add_ci),
    .sum_o(add_sum), .half_o(add_half), .co_o(add_co)
  );

  acc_alu_logic #(.W(W)) u_logic (
    .op_i(op), .a_i(acc_q), .b_i(opnd_i), .res_o(lu_res)
  );

  assign fg_in = is_logic ? lu_res : add_sum;

  acc_alu_flag_gen #(.W(W)) u_flag_gen (
    .res_i(fg_in), .s_o(fg_s), .z_o(fg_z), .p_o(fg_p)
  );

  always_comb begin
    acc_d = acc_q;
    fl_d  = fl_q;
    if (valid_i) begin
      unique case (op)
        OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
          acc_d = add_sum;
          fl_d  = '{s: fg_s, z: fg_z, ac: add_half, p: fg_p,
                    cy: is_sub ? ~add_co : add_co};
        end
        OP_AND, OP_XOR, OP_OR: begin
          acc_d = lu_res;
          fl_d  = '{s: fg_s, z: fg_z, ac: 1'b0, p: fg_p, cy: 1'b0};
        end
        OP_LOAD: acc_d = opnd_i;
        OP_CMA:  acc_d = ~acc_q;
        OP_CMC:  fl_d.cy = ~fl_q.cy;
        OP_INC, OP_DEC: begin
          fl_d.s  = fg_s;
          fl_d.z  = fg_z;
          fl_d.ac = add_half;
          fl_d.p  = fg_p;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      fl_q  <= '0;
    end else begin
      acc_q <= acc_d;
      fl_q  <= fl_d;
    end
  end

  assign acc_o     = acc_q;
  assign flags_o   = fl_q;
  assign idu_res_o = add_sum;
  assign idu_we_o  = valid_i && is_idu;

  // R2
  arith_zero_parity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i < 4'd7) |=> (flags_o[3] == (acc_o == '0)) && (flags_o[1] == ~^acc_o)
                                 && (flags_o[4] == acc_o[W-1]));

  // R6
  cma_keeps_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd8) |=> $stable(flags_o));

  // R7
  cmc_flips_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd9) |=> (flags_o[0] != $past(flags_o[0])) && $stable(flags_o[4:1])
                                 && $stable(acc_o));

  // R8
  idu_keeps_carry_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 4'd10 || op_i == 4'd11)) |=> $stable(flags_o[0]) && $stable(acc_o));

  // R8
  idu_we_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idu_we_o |-> valid_i);

  // R9
  idle_holds_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i || op_i >= 4'd12) |=> $stable(acc_o) && $stable(flags_o));
endmodule

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] op_i = 4'd0;
  logic [7:0] opnd_i = 8'd0;
  logic [7:0] acc_o, idu_res_o;
  logic [4:0] flags_o;
  logic       idu_we_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // bench model state
  logic [7:0] m_acc = 8'd0;
  logic [4:0] m_fl = 5'd0;  // {S,Z,AC,P,CY}
  logic [7:0] e_res;
  logic       e_we;

  always #2.5 clk_i = ~clk_i;

  acc_alu u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .opnd_i(opnd_i),
    .acc_o(acc_o), .flags_o(flags_o), .idu_res_o(idu_res_o), .idu_we_o(idu_we_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic even_par(input logic [7:0] r);
    int n = 0;
    for (int i = 0; i < 8; i++) n += r[i];
    return (n % 2) == 0;
  endfunction

  // reference model from the requirements
  task automatic model(input logic v, input int op, input int b);
    int a, c, t, ac, cy;
    logic [7:0] r;
    a = m_acc; c = m_fl[0];
    e_we = 1'b0; e_res = 8'hxx;
    if (!v) return;
    case (op)
      0, 1, 2, 3: begin
        if (op < 2) begin
          t = a + b + (op == 1 ? c : 0);
          cy = (t > 255);
          ac = ((a & 15) + (b & 15) + (op == 1 ? c : 0)) > 15;
        end else begin
          t = a - b - (op == 3 ? c : 0);
          cy = (b + (op == 3 ? c : 0)) > a;
          ac = ((a & 15) + ((~b) & 15) + (op == 3 ? 1 - c : 1)) > 15;
        end
        r = t[7:0];
        m_acc = r;
        m_fl = {r[7], r == 0, ac[0], even_par(r), cy[0]};
      end
      4, 5, 6: begin
        r = (op == 4) ? (a & b) : (op == 5) ? (a ^ b) : (a | b);
        m_acc = r;
        m_fl = {r[7], r == 0, 1'b0, even_par(r), 1'b0};
      end
      7: m_acc = b[7:0];
      8: m_acc = ~m_acc;
      9: m_fl[0] = ~m_fl[0];
      10, 11: begin
        r = (op == 10) ? 8'(b + 1) : 8'(b - 1);
        ac = (op == 10) ? ((b & 15) == 15) : ((b & 15) != 0);
        e_res = r; e_we = 1'b1;
        m_fl = {r[7], r == 0, ac[0], even_par(r), m_fl[0]};
      end
      default: ;
    endcase
  endtask

  task automatic do_op(input string tag, input logic v, input int op, input int b);
    @(negedge clk_i);
    valid_i = v; op_i = op[3:0]; opnd_i = b[7:0];
    model(v, op, b);
    #1;
    chk({tag, " idu_we"}, idu_we_o, e_we);
    if (e_we) chk({tag, " idu_res"}, idu_res_o, e_res);
    @(posedge clk_i);
    #1;
    valid_i = 1'b0;
    chk({tag, " acc"}, acc_o, m_acc);
    chk({tag, " flags"}, flags_o, m_fl);
  endtask

  task automatic t_reset;
    chk("R10 reset acc", acc_o, 0);
    chk("R10 reset flags", flags_o, 0);
  endtask

  task automatic t_add;
    do_op("R1 load", 1, 7, 8'h3A);
    do_op("R1 R2 R3 add", 1, 0, 8'h06);        // 3A+06: half carry
    do_op("R4 add carry", 1, 0, 8'hC0);        // wraps, CY set
    do_op("R1 R4 adc", 1, 1, 8'h01);           // uses CY
    do_op("R2 add zero", 1, 7, 8'h80);
    do_op("R2 R4 add to zero", 1, 0, 8'h80);
  endtask

  task automatic t_sub;
    do_op("R1 load", 1, 7, 8'h10);
    do_op("R3 R4 sub borrow", 1, 2, 8'h11);    // 10-11 borrow
    do_op("R3 R4 sbb", 1, 3, 8'h0F);           // uses borrow
    do_op("R1 R4 sub nb", 1, 2, 8'h01);
    do_op("R2 sub equal", 1, 2, acc_o);
    do_op("R4 sbb edge", 1, 3, 8'h00);
  endtask

  task automatic t_logic;
    do_op("R1 load", 1, 7, 8'hF3);
    do_op("R4 set cy", 1, 0, 8'hFF);
    do_op("R5 and", 1, 4, 8'h5A);
    do_op("R4 set cy", 1, 0, 8'hFF);
    do_op("R5 xor", 1, 5, 8'h96);
    do_op("R5 or", 1, 6, 8'h00);
  endtask

  task automatic t_cma_cmc;
    do_op("R6 cma", 1, 8, 8'h00);
    do_op("R7 cmc", 1, 9, 8'h00);
    do_op("R7 cmc again", 1, 9, 8'h00);
    do_op("R6 load keeps flags", 1, 7, 8'h00);
  endtask

  task automatic t_idu;
    do_op("R4 set cy", 1, 0, 8'hFF);
    do_op("R8 inc", 1, 10, 8'h0F);
    do_op("R8 inc wrap", 1, 10, 8'hFF);
    do_op("R8 dec wrap", 1, 11, 8'h00);
    do_op("R8 dec", 1, 11, 8'h11);
    do_op("R8 dec to zero", 1, 11, 8'h01);
  endtask

  task automatic t_ignore;
    do_op("R9 valid low", 0, 0, 8'h55);
    do_op("R9 valid low inc", 0, 10, 8'h55);
    do_op("R9 op 12", 1, 12, 8'h55);
    do_op("R9 op 15", 1, 15, 8'hAA);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_add();
    t_sub();
    t_logic();
    t_cma_cmc();
    t_idu();
    t_ignore();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule